// File: doc/BRIEF.md
# Commutation-Synchronized Six-Step PWM Generator

This block drives the three upper and three lower gate enables of a three-phase inverter that runs a sensorless brushless DC motor with two-phase excitation. A commutation controller supplies a step index from 0 to 5, one per 60 electrical degrees, together with a one-cycle commutation pulse. In every legal step exactly one upper switch and one lower switch on different phases conduct. One switch of that pair is chopped by a counter-based PWM carrier, and the other is held fully on.

The carrier is not free-running. In immediate mode a commutation pulse cuts the running PWM period short, so the new switch pair and a fresh period both start on the next clock. In deferred mode the new step waits for the natural end of the running period, which can add up to one full period of delay. A restart that cuts a period below half its nominal length is reported on a one-cycle flag, because such a cut means a burst of switching well above the nominal frequency. A scheme select chooses which switch of the pair is chopped: always the upper one, always the lower one, the switch whose phase has just joined the pair, or the switch whose phase carries over from the previous step.

Top module: `cpwm_sixstep`

## Requirements
- R1: While reset is high and in the first cycle after it, all six gate enables, `period_start_o` and `short_period_o` are 0. After reset no step is applied, so the gates stay off until a commutation pulse arrives.
- R2: Phase A is bit 0, B is bit 1 and C is bit 2 of `gate_hi_o` and `gate_lo_o`. Steps 0 to 5 select (upper, lower) pairs (A,B), (A,C), (B,C), (B,A), (C,A), (C,B). No phase ever has both enables high, and at most one bit of each vector is high.
- R3: An applied step of 6 or 7 turns all six gate enables off.
- R4: A latched period word P gives a period of P clock cycles, and any value below 2 counts as 2. `period_start_o` is high in the first cycle of every period.
- R5: Within a period the cycle count runs up from 0, and the chopped switch is on while that count is below the latched duty word. A duty of 0 keeps it off for the whole period, and a duty of P or more keeps it on for the whole period.
- R6: `scheme_i` encoding: 0 chops the upper switch, 1 chops the lower switch, 2 (ongoing) chops the upper switch on even steps and the lower switch on odd steps, 3 (offgoing) chops the lower switch on even steps and the upper switch on odd steps. The switch that is not chopped stays fully on.
- R7: With `immediate_i` = 1, a commutation pulse makes the next cycle show the new step's pattern at count 0, with `period_start_o` high.
- R8: With `immediate_i` = 0, a commutation pulse that does not fall on the last cycle of a period leaves the old pattern in place until the period ends. The new step takes effect together with the next period start. A later pulse replaces a step that is still waiting.
- R9: A commutation pulse on the last cycle of a period gives the same result in both modes: the new step appears at once, with the new period.
- R10: `short_period_o` pulses high, together with `period_start_o`, when an immediate commutation ends a period after k cycles with 2k < P. It is not raised when the pulse falls on the period's last cycle.
- R11: The duty and period words are taken only on the cycle a period starts. Changes at any other time take effect at the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 3 | Commutation step index, valid with commut_i |
| commut_i | input | 1 | One-cycle commutation event |
| immediate_i | input | 1 | 1: restart the period on commutation, 0: defer to period end |
| scheme_i | input | 2 | Chopped-switch scheme select |
| duty_i | input | CNT_W | Duty word, taken at period start |
| period_i | input | CNT_W | Period length in cycles, taken at period start |
| gate_hi_o | output | 3 | Upper switch enables, bit 0 = phase A |
| gate_lo_o | output | 3 | Lower switch enables, bit 0 = phase A |
| period_start_o | output | 1 | High in the first cycle of each PWM period |
| short_period_o | output | 1 | High when a restart truncated the previous period below half |

## Verification
A commutation pulse and the natural end of a PWM period can fall in the same cycle. The stimulus provokes this by holding a steady period and timing pulses to land on its last count, once in deferred mode and once in immediate mode. It then checks that the new step appears at once, with exactly one period start and no short-period flag. The same cycle-level reference model also judges the contrasting cases: early cuts that must raise the flag, and deferred pulses that must wait.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic [1:0] {
    CHOP_UPPER    = 2'd0,
    CHOP_LOWER    = 2'd1,
    CHOP_ONGOING  = 2'd2,
    CHOP_OFFGOING = 2'd3
  } chop_scheme_e;

  localparam int PHASES = 3;
  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] STEP_OFF = 3'd7;

  // upper phase of a legal step
  function automatic logic [1:0] upper_phase(input logic [STEP_W-1:0] s);
    return s[2:1];
  endfunction

  // lower phase of a legal step
  function automatic logic [1:0] lower_phase(input logic [STEP_W-1:0] s);
    logic [1:0] p;
    case (s)
      3'd0, 3'd5: p = 2'd1;
      3'd1, 3'd2: p = 2'd2;
      default:    p = 2'd0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cut_req_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             wrap_o,
  output logic             restart_o,
  output logic             cut_short_o,
  output logic             chop_next_o
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, per_q, duty_q;
  logic [CNT_W-1:0] cnt_n, per_n, duty_n;
  logic [CNT_W:0]   elapsed;
  logic [CNT_W+1:0] elapsed_x2;

  always_comb begin
    wrap_o     = (cnt_q == per_q - ONE);
    restart_o  = cut_req_i | wrap_o;
    cnt_n      = restart_o ? '0 : cnt_q + ONE;
    per_n      = restart_o ? ((period_i < MIN_PER) ? MIN_PER : period_i) : per_q;
    duty_n     = restart_o ? duty_i : duty_q;
    elapsed    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    elapsed_x2 = {elapsed, 1'b0};
    cut_short_o = cut_req_i & ~wrap_o & (elapsed_x2 < {2'b00, per_q});
    chop_next_o = (cnt_n < duty_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      per_q  <= MIN_PER;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      per_q  <= per_n;
      duty_q <= duty_n;
    end
  end

  // R4: count stays inside the latched period
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < per_q);

  // R11: period and duty words only move at a period start
  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !restart_o |=> ($stable(duty_q) && $stable(per_q)));

endmodule

// File: rtl/cpwm_sequencer.sv
module cpwm_sequencer
  import cpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commut_i,
  input  logic              immediate_i,
  input  logic              wrap_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [STEP_W-1:0] step_next_o
);
  logic [STEP_W-1:0] step_q, pstep_q, pstep_n;
  logic              pend_q, pend_n;

  always_comb begin
    step_next_o = step_q;
    pend_n      = pend_q;
    pstep_n     = pstep_q;
    if (commut_i && (immediate_i || wrap_i)) begin
      step_next_o = step_i;
      pend_n      = 1'b0;
    end else if (commut_i) begin
      pend_n  = 1'b1;
      pstep_n = step_i;
    end else if (wrap_i && pend_q) begin
      step_next_o = pstep_q;
      pend_n      = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= STEP_OFF;
      pstep_q <= STEP_OFF;
      pend_q  <= 1'b0;
    end else begin
      step_q  <= step_next_o;
      pstep_q <= pstep_n;
      pend_q  <= pend_n;
    end
  end

  // R8: a waiting step is installed when the period ends
  assert_pend_applied_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q && wrap_i && !commut_i) |=> (!pend_q && step_q == $past(pstep_q)));

endmodule

// File: rtl/cpwm_gate_map.sv
module cpwm_gate_map
  import cpwm_pkg::*;
(
  input  logic              [STEP_W-1:0] step_i,
  input  logic                           chop_i,
  input  chop_scheme_e                   scheme_i,
  output logic              [PHASES-1:0] hi_o,
  output logic              [PHASES-1:0] lo_o
);
  logic       legal, chop_upper;
  logic [1:0] up_ph, dn_ph;

  always_comb begin
    legal = (step_i < 3'd6);
    up_ph = upper_phase(step_i);
    dn_ph = lower_phase(step_i);
    case (scheme_i)
      CHOP_UPPER:   chop_upper = 1'b1;
      CHOP_LOWER:   chop_upper = 1'b0;
      CHOP_ONGOING: chop_upper = ~step_i[0];
      default:      chop_upper = step_i[0];
    endcase
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_comb begin
      hi_o[p] = legal && (up_ph == 2'(p)) && (chop_upper ? chop_i : 1'b1);
      lo_o[p] = legal && (dn_ph == 2'(p)) && (chop_upper ? 1'b1 : chop_i);
    end
  end

endmodule

// File: rtl/cpwm_sixstep.sv
module cpwm_sixstep
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       step_i,
  input  logic             commut_i,
  input  logic             immediate_i,
  input  logic [1:0]       scheme_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [2:0]       gate_hi_o,
  output logic [2:0]       gate_lo_o,
  output logic             period_start_o,
  output logic             short_period_o
);
  logic              wrap, restart, cut_short, chop_next;
  logic [STEP_W-1:0] step_next;
  logic [PHASES-1:0] hi_n, lo_n;

  cpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk         (clk),
    .rst         (rst),
    .cut_req_i   (commut_i & immediate_i),
    .duty_i      (duty_i),
    .period_i    (period_i),
    .wrap_o      (wrap),
    .restart_o   (restart),
    .cut_short_o (cut_short),
    .chop_next_o (chop_next)
  );

  cpwm_sequencer u_seq (
    .clk         (clk),
    .rst         (rst),
    .commut_i    (commut_i),
    .immediate_i (immediate_i),
    .wrap_i      (wrap),
    .step_i      (step_i),
    .step_next_o (step_next)
  );

  cpwm_gate_map u_map (
    .step_i   (step_next),
    .chop_i   (chop_next),
    .scheme_i (chop_scheme_e'(scheme_i)),
    .hi_o     (hi_n),
    .lo_o     (lo_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi_o      <= '0;
      gate_lo_o      <= '0;
      period_start_o <= 1'b0;
      short_period_o <= 1'b0;
    end else begin
      gate_hi_o      <= hi_n;
      gate_lo_o      <= lo_n;
      period_start_o <= restart;
      short_period_o <= cut_short;
    end
  end

  // R2: never both switches of one leg, at most one per rail
  assert_no_shoot_R2: assert property (@(posedge clk) disable iff (rst)
    ((gate_hi_o & gate_lo_o) == 3'b000) &&
    ($countones(gate_hi_o) <= 1) && ($countones(gate_lo_o) <= 1));

  // R7: immediate commutation starts a new period next cycle
  assert_imm_start_R7: assert property (@(posedge clk) disable iff (rst)
    (commut_i && immediate_i) |=> period_start_o);

  // R3: illegal step applied at once leaves every gate off
  assert_illegal_off_R3: assert property (@(posedge clk) disable iff (rst)
    (commut_i && immediate_i && step_i >= 3'd6) |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

  // R10: short flag only accompanies a period start
  assert_short_start_R10: assert property (@(posedge clk) disable iff (rst)
    short_period_o |-> period_start_o);

  // R8: deferred pulse mid-period does not restart the carrier
  assert_defer_no_start_R8: assert property (@(posedge clk) disable iff (rst)
    (commut_i && !immediate_i && !wrap) |=> !period_start_o);

endmodule

// File: tb/sim_cpwm_sixstep.sv
`timescale 1ns/100ps
module sim_cpwm_sixstep;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] step_i = 3'd0;
  logic       commut_i = 1'b0;
  logic       immediate_i = 1'b1;
  logic [1:0] scheme_i = 2'd0;
  logic [7:0] duty_i = 8'd0;
  logic [7:0] period_i = 8'd8;
  logic [2:0] gate_hi_o, gate_lo_o;
  logic       period_start_o, short_period_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpwm_sixstep #(.CNT_W(8)) u0 (
    .clk(clk), .rst(rst), .step_i(step_i), .commut_i(commut_i),
    .immediate_i(immediate_i), .scheme_i(scheme_i), .duty_i(duty_i),
    .period_i(period_i), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o),
    .period_start_o(period_start_o), .short_period_o(short_period_o)
  );

  // ---------------- reference model from the requirements ----------------
  int m_cnt, m_len, m_duty, m_step, m_pstep;
  bit m_pend;
  logic [2:0] e_hi, e_lo;
  logic e_ps, e_sh;

  task automatic model_gates(input int st, input bit on, input int sch,
                             output logic [2:0] h, output logic [2:0] l);
    int up, dn;
    bit chop_up;
    h = 3'b000;
    l = 3'b000;
    if (st > 5) return;
    case (st)
      0: begin up = 0; dn = 1; end
      1: begin up = 0; dn = 2; end
      2: begin up = 1; dn = 2; end
      3: begin up = 1; dn = 0; end
      4: begin up = 2; dn = 0; end
      default: begin up = 2; dn = 1; end
    endcase
    chop_up = (sch == 0) || (sch == 2 && st % 2 == 0) || (sch == 3 && st % 2 == 1);
    h[up] = chop_up ? on : 1'b1;
    l[dn] = chop_up ? 1'b1 : on;
  endtask

  always @(posedge clk) begin
    bit at_end, cut;
    if (rst) begin
      m_cnt = 0; m_len = 2; m_duty = 0; m_step = 7; m_pstep = 7; m_pend = 0;
      e_hi = 3'b000; e_lo = 3'b000; e_ps = 1'b0; e_sh = 1'b0;
    end else begin
      at_end = (m_cnt == m_len - 1);
      cut = commut_i && immediate_i;
      e_sh = cut && !at_end && (2 * (m_cnt + 1) < m_len);
      if (commut_i && (immediate_i || at_end)) begin
        m_step = int'(step_i); m_pend = 0;
      end else if (commut_i) begin
        m_pend = 1; m_pstep = int'(step_i);
      end else if (at_end && m_pend) begin
        m_step = m_pstep; m_pend = 0;
      end
      if (cut || at_end) begin
        m_cnt = 0;
        m_len = (period_i < 8'd2) ? 2 : int'(period_i);
        m_duty = int'(duty_i);
        e_ps = 1'b1;
      end else begin
        m_cnt = m_cnt + 1;
        e_ps = 1'b0;
      end
      model_gates(m_step, m_cnt < m_duty, int'(scheme_i), e_hi, e_lo);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string what, input int tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input int tag);
    chk("gate_hi", tag, gate_hi_o, e_hi);
    chk("gate_lo", tag, gate_lo_o, e_lo);
    chk("period_start", (tag == 10) ? 10 : 4, {2'b00, period_start_o}, {2'b00, e_ps});
    chk("short_period", 10, {2'b00, short_period_o}, {2'b00, e_sh});
  endtask

  typedef struct packed {
    logic [2:0] step;
    logic       cm;
    logic       imm;
    logic [1:0] sch;
    logic [7:0] duty;
    logic [7:0] per;
    logic [7:0] hold;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{3'd0, 1'b1, 1'b1, 2'd0, 8'd4, 8'd8, 8'd10, 4'd7},  // R7 immediate start, upper chopped
    '{3'd1, 1'b1, 1'b1, 2'd0, 8'd4, 8'd8, 8'd3,  4'd10}, // R10 early cut
    '{3'd2, 1'b1, 1'b1, 2'd1, 8'd6, 8'd8, 8'd9,  4'd6},  // R6 lower scheme
    '{3'd3, 1'b1, 1'b1, 2'd2, 8'd3, 8'd8, 8'd9,  4'd6},  // R6 ongoing, odd step
    '{3'd4, 1'b1, 1'b1, 2'd3, 8'd3, 8'd8, 8'd9,  4'd6},  // R6 offgoing, even step
    '{3'd5, 1'b1, 1'b0, 2'd2, 8'd5, 8'd8, 8'd12, 4'd8},  // R8 deferred wait
    '{3'd0, 1'b1, 1'b0, 2'd3, 8'd0, 8'd6, 8'd8,  4'd5},  // R5 duty zero
    '{3'd1, 1'b1, 1'b1, 2'd0, 8'd9, 8'd6, 8'd8,  4'd5},  // R5 duty above period
    '{3'd6, 1'b1, 1'b1, 2'd0, 8'd3, 8'd6, 8'd4,  4'd3},  // R3 illegal step
    '{3'd2, 1'b1, 1'b1, 2'd0, 8'd2, 8'd5, 8'd5,  4'd4},  // R4 period of five
    '{3'd3, 1'b1, 1'b0, 2'd0, 8'd2, 8'd5, 8'd5,  4'd9},  // R9 deferred pulse on last count
    '{3'd4, 1'b1, 1'b1, 2'd0, 8'd2, 8'd5, 8'd5,  4'd9},  // R9 immediate pulse on last count
    '{3'd5, 1'b0, 1'b1, 2'd0, 8'd1, 8'd9, 8'd8,  4'd11}, // R11 words change mid-period
    '{3'd7, 1'b1, 1'b0, 2'd1, 8'd3, 8'd6, 8'd12, 4'd3}   // R3 step seven, deferred
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("reset gate_hi", 1, gate_hi_o, 3'b000);
    chk("reset gate_lo", 1, gate_lo_o, 3'b000);
    chk("reset flags", 1, {1'b0, period_start_o, short_period_o}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    chk("post-reset gates off R1", 1, gate_hi_o | gate_lo_o, 3'b000);
    chk_all(1);

    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < int'(VT[v].hold); c++) begin
        step_i      = VT[v].step;
        commut_i    = (c == 0) ? VT[v].cm : 1'b0;
        immediate_i = VT[v].imm;
        scheme_i    = VT[v].sch;
        duty_i      = VT[v].duty;
        period_i    = VT[v].per;
        @(negedge clk);
        chk_all(int'(VT[v].tag));
      end
    end
    commut_i = 1'b0;

    // R2: hand check, step 1 upper scheme full duty: A upper, C lower
    step_i = 3'd1; commut_i = 1'b1; immediate_i = 1'b1; scheme_i = 2'd0;
    duty_i = 8'd20; period_i = 8'd4;
    @(negedge clk);
    commut_i = 1'b0;
    chk("hand step1 hi R2", 2, gate_hi_o, 3'b001);
    chk("hand step1 lo R2", 2, gate_lo_o, 3'b100);
    chk_all(2);
    // R3: hand check, illegal step 6 applied at once
    step_i = 3'd6; commut_i = 1'b1;
    @(negedge clk);
    commut_i = 1'b0;
    chk("hand illegal R3", 3, gate_hi_o | gate_lo_o, 3'b000);

    // R1: reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("mid reset R1", 1, gate_hi_o | gate_lo_o, 3'b000);
    chk("mid reset flags R1", 1, {1'b0, period_start_o, short_period_o}, 3'b000);
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("gates off until commutation R1", 1, gate_hi_o | gate_lo_o, 3'b000);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule